// File: doc/BRIEF.md
# Renaming Register File with Reorder-Buffer Tags

This block is the architectural register file of an out-of-order core that keeps results in a reorder buffer until retirement. Each register stores three things: a committed value, a valid flag and a producer tag. When the valid flag is clear, the tag names the reorder-buffer slot that holds, or will later hold, the newest value for that register. An operand lookup therefore needs two reads. The first goes to this file. The second goes to one reorder-buffer slot picked by the tag. No associative search of the reorder buffer takes place.

The block has two operand read ports. Each port drives the tag of its source register out to an external reorder-buffer lookup. It receives back that slot's value and completion flag. From these it returns either a ready operand or the tag to wait for.

The decode stage uses the rename port to point a destination register at a newly allocated slot. The retire port writes committed results. A retiring result makes its register valid again only if no younger producer has claimed the register since. A flush makes every register valid again and keeps the committed values.

Top module: `rename_rf`

## Requirements
- R1: After reset, every register is valid and holds zero, so every read port returns ready with data 0.
- R2: A read of a valid register returns ready=1 and the register's committed value.
- R3: Each read port drives `rob_tag` with the producer tag stored for its source register.
- R4: A read of a non-valid register whose reorder-buffer slot reports done returns ready=1 and the slot's value (`rob_val`).
- R5: A read of a non-valid register whose slot is not done returns ready=0, with the stored tag zero-extended into the low bits of the data.
- R6: An allocation (`alloc_en`) makes the destination register non-valid from the next cycle, with its tag set to `alloc_tag`.
- R7: Reads in the same cycle as an allocation to the same register see the mapping as it was before that allocation.
- R8: A retirement always writes `ret_val` into `ret_reg`. The register becomes valid only if its stored tag equals `ret_tag`.
- R9: When two writers are allocated back to back to one register, retiring the older one (stale tag) leaves the register non-valid and mapped to the newer tag.
- R10: A flush sets every register valid and leaves committed values unchanged, apart from a retirement in the same cycle. An allocation in the flush cycle is ignored.
- R11: When an allocation and a retirement target the same register in one cycle, the allocation decides the mapping: the register ends non-valid with the new tag, and the retired value is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Make all registers valid again |
| src_idx | input | NUM_SRC x IDX_W | Source register index per read port |
| rob_tag | output | NUM_SRC x TAG_W | Reorder-buffer slot to look up per read port |
| rob_val | input | NUM_SRC x DATA_W | Value held in the looked-up slot |
| rob_done | input | NUM_SRC | Looked-up slot has completed |
| src_rdy | output | NUM_SRC | Operand is available |
| src_data | output | NUM_SRC x DATA_W | Operand value, or the wait tag when not ready |
| alloc_en | input | 1 | Rename a destination register |
| alloc_reg | input | IDX_W | Destination register being renamed |
| alloc_tag | input | TAG_W | Newly allocated slot |
| ret_en | input | 1 | Retire a result |
| ret_reg | input | IDX_W | Register written by the retiring result |
| ret_tag | input | TAG_W | Slot of the retiring result |
| ret_val | input | DATA_W | Retiring value |

## Verification
The assertions assume that `rob_val` and `rob_done` answer the tag currently on `rob_tag` within the same cycle. They also assume that the retire port carries tags the rename port handed out earlier. Both checks on retirement rule out a same-cycle allocation to the same register. In the bench, the reorder-buffer model is a combinational function of `rob_tag`. Retirements reuse only tags the bench allocated itself. It drives one allocation or retirement at a time, except in the dedicated collision and flush steps.

// File: rtl/rename_rf_pkg.sv
package rename_rf_pkg;
    typedef enum logic [1:0] {
        SRC_ARCH = 2'd0,
        SRC_ROB  = 2'd1,
        SRC_WAIT = 2'd2
    } src_sel_e;
endpackage

// File: rtl/rrf_read_port.sv
module rrf_read_port
    import rename_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              ent_vld,
    input  logic [DATA_W-1:0] ent_val,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic              rob_done,
    input  logic [DATA_W-1:0] rob_val,
    output logic              rdy,
    output logic [DATA_W-1:0] data
);
    localparam int PAD_W = DATA_W - TAG_W;

    src_sel_e sel;

    always_comb begin
        if (ent_vld)       sel = SRC_ARCH;
        else if (rob_done) sel = SRC_ROB;
        else               sel = SRC_WAIT;
    end

    always_comb begin
        case (sel)
            SRC_ARCH: begin
                rdy  = 1'b1;
                data = ent_val;
            end
            SRC_ROB: begin
                rdy  = 1'b1;
                data = rob_val;
            end
            default: begin
                rdy  = 1'b0;
                data = {{PAD_W{1'b0}}, ent_tag};
            end
        endcase
    end
endmodule

// File: rtl/rrf_state.sv
module rrf_state #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic                             alloc_en,
    input  logic [IDX_W-1:0]                 alloc_reg,
    input  logic [TAG_W-1:0]                 alloc_tag,
    input  logic                             ret_en,
    input  logic [IDX_W-1:0]                 ret_reg,
    input  logic [TAG_W-1:0]                 ret_tag,
    input  logic [DATA_W-1:0]                ret_val,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  val_q,
    output logic [NUM_REGS-1:0]              vld_q,
    output logic [NUM_REGS-1:0][TAG_W-1:0]   tag_q
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] val;
        logic [NUM_REGS-1:0]             vld;
        logic [NUM_REGS-1:0][TAG_W-1:0]  tag;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // retirement: value always lands, validity only for the newest producer
        if (ret_en) begin
            st_d.val[ret_reg] = ret_val;
            if (st_q.tag[ret_reg] == ret_tag)
                st_d.vld[ret_reg] = 1'b1;
        end
        // flush outranks rename; rename outranks retire re-validation
        if (flush) begin
            st_d.vld = '1;
        end else if (alloc_en) begin
            st_d.vld[alloc_reg] = 1'b0;
            st_d.tag[alloc_reg] = alloc_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.val <= '0;
            st_q.vld <= '1;
            st_q.tag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_q = st_q.val;
    assign vld_q = st_q.vld;
    assign tag_q = st_q.tag;
endmodule

// File: rtl/rename_rf.sv
module rename_rf #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 4,
    parameter int NUM_SRC  = 2,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [NUM_SRC-1:0][IDX_W-1:0]    src_idx,
    output logic [NUM_SRC-1:0][TAG_W-1:0]    rob_tag,
    input  logic [NUM_SRC-1:0][DATA_W-1:0]   rob_val,
    input  logic [NUM_SRC-1:0]               rob_done,
    output logic [NUM_SRC-1:0]               src_rdy,
    output logic [NUM_SRC-1:0][DATA_W-1:0]   src_data,
    input  logic                             alloc_en,
    input  logic [IDX_W-1:0]                 alloc_reg,
    input  logic [TAG_W-1:0]                 alloc_tag,
    input  logic                             ret_en,
    input  logic [IDX_W-1:0]                 ret_reg,
    input  logic [TAG_W-1:0]                 ret_tag,
    input  logic [DATA_W-1:0]                ret_val
);
    logic [NUM_REGS-1:0][DATA_W-1:0] val_q;
    logic [NUM_REGS-1:0]             vld_q;
    logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q;

    rrf_state #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W),
        .TAG_W   (TAG_W)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .alloc_en (alloc_en),
        .alloc_reg(alloc_reg),
        .alloc_tag(alloc_tag),
        .ret_en   (ret_en),
        .ret_reg  (ret_reg),
        .ret_tag  (ret_tag),
        .ret_val  (ret_val),
        .val_q    (val_q),
        .vld_q    (vld_q),
        .tag_q    (tag_q)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign rob_tag[g] = tag_q[src_idx[g]];

        rrf_read_port #(
            .DATA_W(DATA_W),
            .TAG_W (TAG_W)
        ) u_rd (
            .ent_vld (vld_q[src_idx[g]]),
            .ent_val (val_q[src_idx[g]]),
            .ent_tag (tag_q[src_idx[g]]),
            .rob_done(rob_done[g]),
            .rob_val (rob_val[g]),
            .rdy     (src_rdy[g]),
            .data    (src_data[g])
        );
    end
endmodule

// File: rtl/rename_rf_chk.sv
module rename_rf_chk #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 4,
    parameter int NUM_SRC  = 2,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             flush,
    input logic [NUM_SRC-1:0][IDX_W-1:0]    src_idx,
    input logic [NUM_SRC-1:0][TAG_W-1:0]    rob_tag,
    input logic [NUM_SRC-1:0]               rob_done,
    input logic [NUM_SRC-1:0]               src_rdy,
    input logic [NUM_SRC-1:0][DATA_W-1:0]   src_data,
    input logic                             alloc_en,
    input logic [IDX_W-1:0]                 alloc_reg,
    input logic [TAG_W-1:0]                 alloc_tag,
    input logic                             ret_en,
    input logic [IDX_W-1:0]                 ret_reg,
    input logic [TAG_W-1:0]                 ret_tag,
    input logic [DATA_W-1:0]                ret_val,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  val_q,
    input logic [NUM_REGS-1:0]              vld_q,
    input logic [NUM_REGS-1:0][TAG_W-1:0]   tag_q
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_port
        // R2
        a_r2_valid_read: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[src_idx[g]] |-> (src_rdy[g] && src_data[g] == val_q[src_idx[g]]));
        // R5
        a_r5_wait_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (!vld_q[src_idx[g]] && !rob_done[g]) |-> !src_rdy[g]);
        // R4
        a_r4_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (!vld_q[src_idx[g]] && rob_done[g]) |-> src_rdy[g]);
    end

    // R6
    a_r6_alloc_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !flush) |=>
            (!vld_q[$past(alloc_reg)] && tag_q[$past(alloc_reg)] == $past(alloc_tag)));

    // R10
    a_r10_flush_all_valid: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (&vld_q));

    a_r10_flush_keeps_values: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !ret_en) |=> (val_q == $past(val_q)));

    // R8
    a_r8_match_validates: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !flush && !(alloc_en && alloc_reg == ret_reg) && tag_q[ret_reg] == ret_tag) |=>
            (vld_q[$past(ret_reg)] && val_q[$past(ret_reg)] == $past(ret_val)));

    // R9
    a_r9_stale_stays_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !flush && !(alloc_en && alloc_reg == ret_reg) &&
         !vld_q[ret_reg] && tag_q[ret_reg] != ret_tag) |=> !vld_q[$past(ret_reg)]);
endmodule

bind rename_rf rename_rf_chk #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .TAG_W   (TAG_W),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .src_idx  (src_idx),
    .rob_tag  (rob_tag),
    .rob_done (rob_done),
    .src_rdy  (src_rdy),
    .src_data (src_data),
    .alloc_en (alloc_en),
    .alloc_reg(alloc_reg),
    .alloc_tag(alloc_tag),
    .ret_en   (ret_en),
    .ret_reg  (ret_reg),
    .ret_tag  (ret_tag),
    .ret_val  (ret_val),
    .val_q    (val_q),
    .vld_q    (vld_q),
    .tag_q    (tag_q)
);

// File: tb/tb_rename_rf.sv
module tb_rename_rf;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int TW   = 4;
    localparam int NS   = 2;
    localparam int IW   = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   flush;
    logic [NS-1:0][IW-1:0]  src_idx;
    logic [NS-1:0][TW-1:0]  rob_tag;
    logic [NS-1:0][DW-1:0]  rob_val;
    logic [NS-1:0]          rob_done;
    logic [NS-1:0]          src_rdy;
    logic [NS-1:0][DW-1:0]  src_data;
    logic                   alloc_en;
    logic [IW-1:0]          alloc_reg;
    logic [TW-1:0]          alloc_tag;
    logic                   ret_en;
    logic [IW-1:0]          ret_reg;
    logic [TW-1:0]          ret_tag;
    logic [DW-1:0]          ret_val;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // expected architectural state, kept from the requirements
    logic [DW-1:0] m_val [NREG];
    logic          m_vld [NREG];
    logic [TW-1:0] m_tag [NREG];

    always #10 clk = ~clk;

    // reorder-buffer model: slot value is a fixed function of the slot tag
    for (genvar g = 0; g < NS; g++) begin : g_rob
        assign rob_val[g] = 32'hC0DE_0000 | {28'd0, rob_tag[g]};
    end

    rename_rf #(.NUM_REGS(NREG), .DATA_W(DW), .TAG_W(TW), .NUM_SRC(NS)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .src_idx(src_idx), .rob_tag(rob_tag), .rob_val(rob_val), .rob_done(rob_done),
        .src_rdy(src_rdy), .src_data(src_data),
        .alloc_en(alloc_en), .alloc_reg(alloc_reg), .alloc_tag(alloc_tag),
        .ret_en(ret_en), .ret_reg(ret_reg), .ret_tag(ret_tag), .ret_val(ret_val)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // check one port against the model for register r
    task automatic check_port(input int p, input int r, input string req);
        logic          e_rdy;
        logic [DW-1:0] e_dat;
        check(rob_tag[p] == m_tag[r], {req, " R3 rob_tag"}, {28'd0, rob_tag[p]}, {28'd0, m_tag[r]});
        if (m_vld[r]) begin
            e_rdy = 1'b1; e_dat = m_val[r];
        end else if (rob_done[p]) begin
            e_rdy = 1'b1; e_dat = 32'hC0DE_0000 | {28'd0, m_tag[r]};
        end else begin
            e_rdy = 1'b0; e_dat = {28'd0, m_tag[r]};
        end
        check(src_rdy[p] == e_rdy, {req, " ready"}, {31'd0, src_rdy[p]}, {31'd0, e_rdy});
        check(src_data[p] == e_dat, {req, " data"}, src_data[p], e_dat);
    endtask

    // sweep every register on both ports, with both completion states
    task automatic sweep(input string req);
        for (int d = 0; d < 2; d++) begin
            for (int r = 0; r < NREG; r++) begin
                src_idx[0] = IW'(r);
                src_idx[1] = IW'(NREG - 1 - r);
                rob_done   = {NS{d[0]}};
                #1;
                check_port(0, r, req);
                check_port(1, NREG - 1 - r, req);
            end
        end
        rob_done = '0;
    endtask

    task automatic idle_inputs();
        flush = 1'b0; alloc_en = 1'b0; ret_en = 1'b0;
        alloc_reg = '0; alloc_tag = '0; ret_reg = '0; ret_tag = '0; ret_val = '0;
    endtask

    // apply one clock edge with the driven controls and update the model
    task automatic edge_apply();
        @(posedge clk);
        if (ret_en) begin
            if (m_tag[ret_reg] == ret_tag) m_vld[ret_reg] = 1'b1;
            m_val[ret_reg] = ret_val;
        end
        if (flush) begin
            for (int r = 0; r < NREG; r++) m_vld[r] = 1'b1;
        end else if (alloc_en) begin
            m_vld[alloc_reg] = 1'b0;
            m_tag[alloc_reg] = alloc_tag;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; idle_inputs(); src_idx = '0; rob_done = '0;
        for (int r = 0; r < NREG; r++) begin
            m_val[r] = '0; m_vld[r] = 1'b1; m_tag[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        sweep("R1");

        // R2 / R8: retire into every register with matching tag 0
        for (int r = 0; r < NREG; r++) begin
            ret_en = 1'b1; ret_reg = IW'(r); ret_tag = '0; ret_val = 32'h1111 * r + 7;
            edge_apply();
        end
        sweep("R2");

        // R6 / R7: allocate each register to tag r; same-cycle read sees old mapping
        for (int r = 0; r < NREG; r++) begin
            alloc_en = 1'b1; alloc_reg = IW'(r); alloc_tag = TW'(r);
            src_idx[0] = IW'(r); src_idx[1] = IW'(r); rob_done = '0;
            #1;
            check_port(0, r, "R7 same-cycle");
            check_port(1, r, "R7 same-cycle");
            edge_apply();
        end
        sweep("R6 R4 R5");

        // R8: matching retirement re-validates
        ret_en = 1'b1; ret_reg = 4'd3; ret_tag = 4'd3; ret_val = 32'hDEAD_0003;
        edge_apply();
        sweep("R8");

        // R9: back-to-back writers on register 5, older retires first
        alloc_en = 1'b1; alloc_reg = 4'd5; alloc_tag = 4'd9;
        edge_apply();
        ret_en = 1'b1; ret_reg = 4'd5; ret_tag = 4'd5; ret_val = 32'h0BAD_0005;
        edge_apply();
        src_idx[0] = 4'd5; rob_done = '0; #1;
        check(src_rdy[0] == 1'b0, "R9 stale retire kept pending", {31'd0, src_rdy[0]}, 32'd0);
        check(src_data[0] == 32'd9, "R9 newer tag kept", src_data[0], 32'd9);
        sweep("R9");
        ret_en = 1'b1; ret_reg = 4'd5; ret_tag = 4'd9; ret_val = 32'h600D_0005;
        edge_apply();
        sweep("R8 newer retire");

        // R11: allocation and retirement on register 6 in one cycle
        alloc_en = 1'b1; alloc_reg = 4'd6; alloc_tag = 4'd12;
        ret_en = 1'b1; ret_reg = 4'd6; ret_tag = 4'd6; ret_val = 32'h0066_0066;
        edge_apply();
        sweep("R11");

        // R10: flush together with an allocation to register 7
        flush = 1'b1; alloc_en = 1'b1; alloc_reg = 4'd7; alloc_tag = 4'd14;
        edge_apply();
        sweep("R10");
        src_idx[0] = 4'd6; #1;
        check(src_data[0] == 32'h0066_0066, "R11 value written", src_data[0], 32'h0066_0066);
        src_idx[0] = 4'd7; #1;
        check(src_rdy[0] == 1'b1, "R10 alloc ignored", {31'd0, src_rdy[0]}, 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule